// File: doc/BRIEF.md
# Predicated Dataflow Function-Unit Node

This block is one compute tile of a circuit-switched function-unit array. Two operand channels and one optional predicate channel arrive from neighbouring switches. Each channel carries a data word, a validity metabit, a forward ready strobe that marks a token, and a backward credit strobe that returns buffer space to the producer. The tile holds one token per input. When every input it needs holds a token and the downstream side has granted a credit, it fires. Firing consumes those tokens, computes the configured operation and places the result in a one-entry output register with its own validity bit.

Control flow is handled inside the data path. An operand token can be marked invalid, and a predicate can turn a result invalid. In both cases the node still emits a token, so consumers never stall waiting for a result that will not come. A select node forwards whichever of its two inputs is valid, which lets merge points of conditional code map directly onto the array. A small configuration word is shifted in serially and then reused for any number of firings.

Top module: `dfn_node`

## Requirements
- R1: After a synchronous active-low reset, o_rdy, o_vld, o_data and all input credit strobes are 0, the output stage holds one credit, and the configuration is add with no predicate.
- R2: The node fires only when each enabled input slot holds a token, at least one output credit is held, and cfg_en is low. o_rdy is high for one cycle, the cycle after the firing edge, and o_data changes only with such a pulse.
- R3: On firing, each enabled input returns a one-cycle credit strobe in the same cycle as o_rdy. A predicate slot that is not enabled is not consumed and returns no credit. A producer sends a token only when its slot is empty.
- R4: Operation codes in config bits [2:0]: 0 add, 1 subtract (a minus b), 2 multiply (low word), 3 unsigned a less than b (result 1 or 0), 4 bitwise AND. Results wrap to the data width.
- R5: For codes 0 to 4, an invalid operand gives an invalid output token. Any invalid output carries data 0 and is still emitted without stalling.
- R6: When config bit 3 is 1, a predicate token is required. The output is invalid, with data 0, unless the predicate token is valid and its bit 0 is 1.
- R7: Code 5 selects: it forwards operand a if a is valid, otherwise b if b is valid, otherwise an invalid token. It still waits for both tokens.
- R8: While cfg_en is high, one configuration bit from cfg_bit is shifted in per cycle. The first bit shifted ends at config bit 0 after four shifts. No firing happens in any cycle with cfg_en high.
- R9: With no output credit left, the node holds its tokens. A one-cycle o_crd strobe restores one credit, and the node then fires.
- R10: Codes 6 and 7 always produce an invalid token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration word; blocks firing |
| cfg_bit | input | 1 | Serial configuration bit |
| a_rdy | input | 1 | Token strobe, operand a |
| a_data | input | W | Operand a data |
| a_vld | input | 1 | Operand a validity metabit |
| a_crd | output | 1 | Credit strobe back to producer a |
| b_rdy | input | 1 | Token strobe, operand b |
| b_data | input | W | Operand b data |
| b_vld | input | 1 | Operand b validity metabit |
| b_crd | output | 1 | Credit strobe back to producer b |
| p_rdy | input | 1 | Token strobe, predicate |
| p_data | input | W | Predicate data (bit 0 is the condition) |
| p_vld | input | 1 | Predicate validity metabit |
| p_crd | output | 1 | Credit strobe back to predicate producer |
| o_rdy | output | 1 | Output token strobe |
| o_data | output | W | Output data |
| o_vld | output | 1 | Output validity metabit |
| o_crd | input | 1 | Credit strobe from the consumer |

## Verification
The bench waits on a half-filled operand set and checks that no token leaves early. A node that fired on any one token would emit garbage and desynchronise the array. It starves the output of credit and expects the tokens to stay put, where a design that ignored credits would overrun the consumer. It holds cfg_en high while tokens sit ready, which catches a node that computes with a half-shifted operation. It also drives invalid operands, false and invalid predicates, and every select combination, where a wrong node would either stall, leak stale data on an invalid token, or pick the wrong branch.

// File: rtl/dfn_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the dataflow node: operation codes and the layout
// of the serially loaded configuration word.
package dfn_pkg;

    localparam int NUM_IN = 3;   // operand a, operand b, predicate

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_LTU = 3'd3,
        OP_AND = 3'd4,
        OP_SEL = 3'd5
    } node_op_e;

    typedef struct packed {
        logic       pred_en;  // bit 3
        logic [2:0] op;       // bits 2:0
    } node_cfg_t;

    localparam int CFG_W = $bits(node_cfg_t);

endpackage

// File: rtl/dfn_cfg_shift.sv
`timescale 1ns/1ps
// Configuration shift register. Shifts one bit per enabled cycle, moving
// toward bit 0, so the first bit shifted lands in bit 0 after CFG_W shifts.
// Assumes the array drives a full word before relying on the configuration.
module dfn_cfg_shift
    import dfn_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      shift_en,
    input  logic      shift_bit,
    output node_cfg_t cfg
);

    logic [CFG_W-1:0] word_q;

    // Shift register; reset selects add without predicate.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= '0;
        else if (shift_en) word_q <= {shift_bit, word_q[CFG_W-1:1]};
    end

    assign cfg = node_cfg_t'(word_q);

endmodule

// File: rtl/dfn_in_slot.sv
`timescale 1ns/1ps
// One-entry token slot for an input channel. Captures data and validity on
// the token strobe and returns a one-cycle credit when the token is taken.
// Assumes the producer sends only after a credit, so the slot never overruns.
module dfn_in_slot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tok_rdy,
    input  logic [W-1:0] tok_data,
    input  logic         tok_vld,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data,
    output logic         vld,
    output logic         crd
);

    // Occupancy flag and credit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            crd  <= 1'b0;
        end else begin
            full <= (full & ~take) | tok_rdy;
            crd  <= take;
        end
    end

    // Token payload, captured on arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            vld  <= 1'b0;
        end else if (tok_rdy) begin
            data <= tok_data;
            vld  <= tok_vld;
        end
    end

endmodule

// File: rtl/dfn_alu.sv
`timescale 1ns/1ps
// Combinational operation unit with validity propagation. Invalid operands
// or a failing predicate give an invalid result whose data is forced to 0.
module dfn_alu
    import dfn_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   op,
    input  logic         pred_en,
    input  logic [W-1:0] a,
    input  logic         va,
    input  logic [W-1:0] b,
    input  logic         vb,
    input  logic [W-1:0] p,
    input  logic         vp,
    output logic [W-1:0] res,
    output logic         res_v
);

    logic [W-1:0] raw;
    logic         raw_v;
    logic         pred_ok;

    // Raw operation result and its validity before predication.
    always_comb begin
        raw   = '0;
        raw_v = va & vb;
        case (op)
            OP_ADD: raw = a + b;
            OP_SUB: raw = a - b;
            OP_MUL: raw = a * b;
            OP_LTU: raw = {{(W-1){1'b0}}, (a < b)};
            OP_AND: raw = a & b;
            OP_SEL: begin
                raw   = va ? a : b;
                raw_v = va | vb;
            end
            default: raw_v = 1'b0;
        endcase
    end

    // Predicate gate and zeroing of invalid data.
    always_comb begin
        pred_ok = ~pred_en | (vp & p[0]);
        res_v   = raw_v & pred_ok;
        res     = res_v ? raw : '0;
    end

endmodule

// File: rtl/dfn_out_stage.sv
`timescale 1ns/1ps
// Output register and downstream credit counter. Loads the result on fire,
// strobes rdy for one cycle and tracks the credits granted by the consumer.
// Assumes the consumer never returns more credits than it was granted.
module dfn_out_stage #(
    parameter int W        = 16,
    parameter int CRD_W    = 2,
    parameter int INIT_CRD = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [W-1:0] res,
    input  logic         res_v,
    input  logic         crd_in,
    output logic         has_crd,
    output logic         rdy,
    output logic [W-1:0] data,
    output logic         vld
);

    logic [CRD_W-1:0] crd_cnt;

    // Credit count: up on a returned credit, down on a firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crd_cnt <= CRD_W'(INIT_CRD);
        end else begin
            case ({crd_in, fire})
                2'b10:   crd_cnt <= crd_cnt + 1'b1;
                2'b01:   crd_cnt <= crd_cnt - 1'b1;
                default: crd_cnt <= crd_cnt;
            endcase
        end
    end

    assign has_crd = (crd_cnt != '0);

    // One-entry output register with its forward strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy  <= 1'b0;
            data <= '0;
            vld  <= 1'b0;
        end else begin
            rdy <= fire;
            if (fire) begin
                data <= res;
                vld  <= res_v;
            end
        end
    end

endmodule

// File: rtl/dfn_node.sv
`timescale 1ns/1ps
// Predicated dataflow function-unit node. Three input slots (a, b,
// predicate), one configured operation and one credited output channel.
// Fires when every enabled slot is full, a credit is held and no
// configuration shift is under way.
module dfn_node
    import dfn_pkg::*;
#(
    parameter int W        = 16,
    parameter int CRD_W    = 2,
    parameter int INIT_CRD = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_bit,
    input  logic         a_rdy,
    input  logic [W-1:0] a_data,
    input  logic         a_vld,
    output logic         a_crd,
    input  logic         b_rdy,
    input  logic [W-1:0] b_data,
    input  logic         b_vld,
    output logic         b_crd,
    input  logic         p_rdy,
    input  logic [W-1:0] p_data,
    input  logic         p_vld,
    output logic         p_crd,
    output logic         o_rdy,
    output logic [W-1:0] o_data,
    output logic         o_vld,
    input  logic         o_crd
);

    node_cfg_t           cfg;
    logic [NUM_IN-1:0]   in_rdy, in_vld, slot_full, slot_vld, slot_crd, need, take;
    logic [W-1:0]        in_data   [NUM_IN];
    logic [W-1:0]        slot_data [NUM_IN];
    logic [W-1:0]        alu_res;
    logic                alu_v, has_crd, fire;

    dfn_cfg_shift u_cfg (
        .clk(clk), .rst_n(rst_n), .shift_en(cfg_en), .shift_bit(cfg_bit), .cfg(cfg)
    );

    // Gather the input channels into indexed form.
    always_comb begin
        in_rdy     = {p_rdy, b_rdy, a_rdy};
        in_vld     = {p_vld, b_vld, a_vld};
        in_data[0] = a_data;
        in_data[1] = b_data;
        in_data[2] = p_data;
    end

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_slot
        dfn_in_slot #(.W(W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .tok_rdy(in_rdy[gi]), .tok_data(in_data[gi]), .tok_vld(in_vld[gi]),
            .take(take[gi]),
            .full(slot_full[gi]), .data(slot_data[gi]), .vld(slot_vld[gi]),
            .crd(slot_crd[gi])
        );
    end

    // Firing rule: all needed slots full, a credit held, no config shift.
    always_comb begin
        need = {cfg.pred_en, 2'b11};
        fire = ~cfg_en & has_crd & (&(slot_full | ~need));
        take = need & {NUM_IN{fire}};
    end

    dfn_alu #(.W(W)) u_alu (
        .op(cfg.op), .pred_en(cfg.pred_en),
        .a(slot_data[0]), .va(slot_vld[0]),
        .b(slot_data[1]), .vb(slot_vld[1]),
        .p(slot_data[2]), .vp(slot_vld[2]),
        .res(alu_res), .res_v(alu_v)
    );

    dfn_out_stage #(.W(W), .CRD_W(CRD_W), .INIT_CRD(INIT_CRD)) u_out (
        .clk(clk), .rst_n(rst_n), .fire(fire), .res(alu_res), .res_v(alu_v),
        .crd_in(o_crd), .has_crd(has_crd),
        .rdy(o_rdy), .data(o_data), .vld(o_vld)
    );

    assign a_crd = slot_crd[0];
    assign b_crd = slot_crd[1];
    assign p_crd = slot_crd[2];

endmodule

// File: rtl/dfn_node_chk.sv
`timescale 1ns/1ps
// Protocol checker for dfn_node, attached by bind.
module dfn_node_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_en,
    input logic         a_rdy,
    input logic         a_full,
    input logic         a_crd,
    input logic         b_crd,
    input logic         o_rdy,
    input logic [W-1:0] o_data,
    input logic         o_vld
);

    AST_CFG_BLOCKS_FIRE: assert property (@(posedge clk) disable iff (!rst_n) cfg_en |=> !o_rdy); // R8
    AST_INVALID_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) !o_vld |-> (o_data == '0)); // R5
    AST_A_CRD_WITH_OUT:  assert property (@(posedge clk) disable iff (!rst_n) a_crd |-> o_rdy); // R3
    AST_B_CRD_WITH_OUT:  assert property (@(posedge clk) disable iff (!rst_n) b_crd |-> o_rdy); // R3
    AST_NO_OVERRUN:      assert property (@(posedge clk) disable iff (!rst_n) a_rdy |-> !a_full); // R3
    AST_DATA_ONLY_FIRE:  assert property (@(posedge clk) disable iff (!rst_n) !$stable(o_data) |-> o_rdy); // R2

endmodule

bind dfn_node dfn_node_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .a_rdy(a_rdy), .a_full(slot_full[0]), .a_crd(a_crd), .b_crd(b_crd),
    .o_rdy(o_rdy), .o_data(o_data), .o_vld(o_vld)
);

// File: tb/dfn_node_bench.sv
`timescale 1ns/1ps
module dfn_node_bench;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_bit = 1'b0;
    logic a_rdy = 1'b0, a_vld = 1'b0, b_rdy = 1'b0, b_vld = 1'b0, p_rdy = 1'b0, p_vld = 1'b0;
    logic [W-1:0] a_data = '0, b_data = '0, p_data = '0;
    logic a_crd, b_crd, p_crd, o_rdy, o_vld;
    logic [W-1:0] o_data;
    logic o_crd = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dfn_node #(.W(W)) u_dfn_node (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .a_rdy(a_rdy), .a_data(a_data), .a_vld(a_vld), .a_crd(a_crd),
        .b_rdy(b_rdy), .b_data(b_data), .b_vld(b_vld), .b_crd(b_crd),
        .p_rdy(p_rdy), .p_data(p_data), .p_vld(p_vld), .p_crd(p_crd),
        .o_rdy(o_rdy), .o_data(o_data), .o_vld(o_vld), .o_crd(o_crd)
    );

    typedef struct packed {
        logic [2:0]   op;
        logic         pen;
        logic [W-1:0] a;
        logic         va;
        logic [W-1:0] b;
        logic         vb;
        logic [W-1:0] p;
        logic         vp;
        logic [W-1:0] e;
        logic         ev;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b0, 16'd5,     1'b1, 16'd7,     1'b1, 16'd0, 1'b0, 16'd12,     1'b1},
        '{3'd1, 1'b0, 16'd3,     1'b1, 16'd5,     1'b1, 16'd0, 1'b0, 16'hFFFE,   1'b1},
        '{3'd2, 1'b0, 16'd300,   1'b1, 16'd300,   1'b1, 16'd0, 1'b0, 16'd24464,  1'b1},
        '{3'd3, 1'b0, 16'd2,     1'b1, 16'd9,     1'b1, 16'd0, 1'b0, 16'd1,      1'b1},
        '{3'd3, 1'b0, 16'd9,     1'b1, 16'd2,     1'b1, 16'd0, 1'b0, 16'd0,      1'b1},
        '{3'd4, 1'b0, 16'hF0F0,  1'b1, 16'h3C3C,  1'b1, 16'd0, 1'b0, 16'h3030,   1'b1},
        '{3'd0, 1'b0, 16'd5,     1'b0, 16'd7,     1'b1, 16'd0, 1'b0, 16'd0,      1'b0},
        '{3'd5, 1'b0, 16'd11,    1'b1, 16'd22,    1'b1, 16'd0, 1'b0, 16'd11,     1'b1},
        '{3'd5, 1'b0, 16'd11,    1'b0, 16'd22,    1'b1, 16'd0, 1'b0, 16'd22,     1'b1},
        '{3'd5, 1'b0, 16'd11,    1'b0, 16'd22,    1'b0, 16'd0, 1'b0, 16'd0,      1'b0},
        '{3'd0, 1'b1, 16'd5,     1'b1, 16'd7,     1'b1, 16'd1, 1'b1, 16'd12,     1'b1},
        '{3'd0, 1'b1, 16'd5,     1'b1, 16'd7,     1'b1, 16'd0, 1'b1, 16'd0,      1'b0},
        '{3'd5, 1'b1, 16'd11,    1'b0, 16'd22,    1'b1, 16'd0, 1'b1, 16'd0,      1'b0},
        '{3'd2, 1'b1, 16'd4,     1'b1, 16'd4,     1'b1, 16'd1, 1'b0, 16'd0,      1'b0},
        '{3'd6, 1'b0, 16'd1,     1'b1, 16'd1,     1'b1, 16'd0, 1'b0, 16'd0,      1'b0}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [2:0] op, input logic pen);
        logic [3:0] bits;
        bits = {pen, op};
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_bit = bits[k];
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic send(input logic [2:0] mask, input logic [W-1:0] a, input logic va,
                        input logic [W-1:0] b, input logic vb, input logic [W-1:0] p, input logic vp);
        @(negedge clk);
        a_rdy = mask[0]; a_data = a; a_vld = va;
        b_rdy = mask[1]; b_data = b; b_vld = vb;
        p_rdy = mask[2]; p_data = p; p_vld = vp;
        @(negedge clk);
        a_rdy = 1'b0; b_rdy = 1'b0; p_rdy = 1'b0;
    endtask

    // Returns at the negedge where o_rdy is high, or after a timeout.
    task automatic wait_out(output bit got);
        got = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (o_rdy) begin
                got = 1'b1;
                return;
            end
            @(negedge clk);
        end
    endtask

    task automatic give_crd;
        @(negedge clk);
        o_crd = 1'b1;
        @(negedge clk);
        o_crd = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit got;
        bit seen;
        string tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "o_rdy", o_rdy, 0);
        chk("R1", "o_vld", o_vld, 0);
        chk("R1", "o_data", o_data, 0);
        chk("R1", "a_crd", a_crd, 0);
        // R1: default configuration adds, one credit held
        send(3'b011, 16'd2, 1'b1, 16'd3, 1'b1, 16'd0, 1'b0);
        wait_out(got);
        chk("R1", "fire", got, 1);
        chk("R1", "sum", o_data, 16'd5);
        give_crd();

        // Table of operations
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].op > 3'd5)       tag = "R10";
            else if (VEC[i].pen)        tag = "R6";
            else if (VEC[i].op == 3'd5) tag = "R7";
            else if (!(VEC[i].va && VEC[i].vb)) tag = "R5";
            else                        tag = "R4";
            load_cfg(VEC[i].op, VEC[i].pen);
            send({VEC[i].pen, 2'b11}, VEC[i].a, VEC[i].va, VEC[i].b, VEC[i].vb, VEC[i].p, VEC[i].vp);
            wait_out(got);
            chk(tag, "fire", got, 1);
            chk(tag, "data", o_data, VEC[i].e);
            chk(tag, "vld", o_vld, VEC[i].ev);
            give_crd();
        end

        // R2: partial operands do not fire
        load_cfg(3'd0, 1'b0);
        send(3'b001, 16'd10, 1'b1, 16'd0, 1'b0, 16'd0, 1'b0);
        seen = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (o_rdy) seen = 1'b1;
        end
        chk("R2", "early fire", seen, 0);
        send(3'b010, 16'd0, 1'b0, 16'd20, 1'b1, 16'd0, 1'b0);
        wait_out(got);
        chk("R2", "fire", got, 1);
        chk("R2", "data", o_data, 16'd30);
        chk("R3", "a_crd", a_crd, 1);
        chk("R3", "b_crd", b_crd, 1);
        chk("R3", "p_crd unused", p_crd, 0);
        @(negedge clk);
        chk("R2", "pulse width", o_rdy, 0);
        give_crd();

        // R9: no credit -> tokens held
        send(3'b011, 16'd1, 1'b1, 16'd1, 1'b1, 16'd0, 1'b0);
        wait_out(got);
        chk("R9", "first", o_data, 16'd2);
        send(3'b011, 16'd4, 1'b1, 16'd5, 1'b1, 16'd0, 1'b0);
        seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (o_rdy || a_crd) seen = 1'b1;
        end
        chk("R9", "fired without credit", seen, 0);
        chk("R9", "held data", o_data, 16'd2);
        give_crd();
        wait_out(got);
        chk("R9", "fire after credit", got, 1);
        chk("R9", "data", o_data, 16'd9);
        give_crd();

        // R8: shifting blocks firing
        seen = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k > 0 && o_rdy) seen = 1'b1;
            cfg_en  = 1'b1;
            cfg_bit = 1'b0;
            a_rdy = (k == 0); a_data = 16'd7; a_vld = 1'b1;
            b_rdy = (k == 0); b_data = 16'd8; b_vld = 1'b1;
        end
        @(negedge clk);
        if (o_rdy) seen = 1'b1;
        cfg_en = 1'b0;
        chk("R8", "fire during shift", seen, 0);
        @(negedge clk);
        wait_out(got);
        chk("R8", "fire after shift", got, 1);
        chk("R8", "data", o_data, 16'd15);
        give_crd();

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule